// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver with Address Filtering

This block receives asynchronous serial characters made of one low start bit, eight data bits sent least significant bit first, and one stop bit. It runs on the system clock and advances only on an oversample enable that pulses at sixteen times the bit rate. The line is resynchronised through a two-flop chain and treated as high when idle. A falling level between two consecutive oversample points starts a reception. At that point a sixteen-state phase counter restarts, so each bit period has a fixed phase relation to the edge. Three consecutive oversample points in the middle of each bit are combined by a two-of-three vote.

A start bit whose vote comes out high is treated as noise: the receiver drops the attempt and waits for another falling edge. When the stop bit has been voted, the receiver decides whether to keep the character. The character is kept only when the ready flag is clear, and only when the filter input is low or the stop bit is high. A kept character loads the byte register and the stop-bit register and raises the ready flag. A character that is not kept leaves both registers untouched. Software lowers the flag with a one-cycle clear pulse. Setting the flag takes priority over that pulse. The receiver is back in idle right after the stop-bit vote, so the next start edge can come before the nominal end of the stop bit.

Top module: `mpuart_rx`

## Requirements
- R1: While reset is asserted and after it is released, `rx_byte` is 0x00, `rx_stop` is 0 and `rx_ready` is 0.
- R2: When `rx_ready` is 0 and `filter_en` is 0, a well-formed character is delivered. The first data bit received lands in `rx_byte[0]`, the stop-bit level lands in `rx_stop`, and `rx_ready` becomes 1.
- R3: Each bit is decided by a majority of three oversample points at phases 7, 8 and 9 of the bit. A disturbance that covers a single oversample point does not change the delivered byte.
- R4: A low pulse on an idle line shorter than half a bit period starts no delivery. The receiver returns to waiting for a falling edge, and a character that follows is received correctly.
- R5: A character that completes while `rx_ready` is 1 is discarded. `rx_byte`, `rx_stop` and `rx_ready` stay as they were.
- R6: With `filter_en` at 1, a character whose stop bit is 0 is discarded and leaves the registers unchanged, while one whose stop bit is 1 is delivered. With `filter_en` at 0, a character whose stop bit is 0 is delivered and `rx_stop` reads 0.
- R7: A one-cycle pulse on `ready_clr` lowers `rx_ready`. When a delivery and `ready_clr` fall in the same cycle, `rx_ready` ends up at 1.
- R8: A start edge that comes 52 system clocks into the stop bit of the previous character is accepted, with the oversample enable at every fourth clock. That is less than one bit period, and the following character is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, sixteen pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| filter_en | input | 1 | Address filter mode: when 1, only characters with a high stop bit are kept |
| ready_clr | input | 1 | Software clear pulse for the ready flag |
| rx_byte | output | 8 | Last delivered data byte |
| rx_stop | output | 1 | Stop-bit level of the last delivered character |
| rx_ready | output | 1 | Ready flag, set on delivery |

## Verification
Delivery of a character and a software clear of the ready flag can fall in the same clock cycle, and the outcome depends on which of the two wins. The bench provokes this by holding `ready_clr` high for the whole of a character, so the clear is active on the exact cycle the stop bit is voted. It releases the clear on the first sampling point at which `rx_ready` reads 1. The design is judged correct when the flag stays at 1 and the new byte is in place. A design in which the clear wins would never show the flag rising, and the check would report this.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = din;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mpuart_rx_sampler.sv
module mpuart_rx_sampler #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic align,
  input  logic rx,
  output logic strobe,
  output logic vote
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] PH_A = CW'(MID - 1);
  localparam logic [CW-1:0] PH_B = CW'(MID);
  localparam logic [CW-1:0] PH_C = CW'(MID + 1);

  logic [CW-1:0] phase_q, phase_d;
  logic [1:0]    smp_q, smp_d;

  always_comb begin
    phase_d = phase_q;
    smp_d   = smp_q;
    if (tick) begin
      if (align)       phase_d = '0;
      else if (active) phase_d = phase_q + 1'b1;
      if (active && phase_q == PH_A) smp_d[0] = rx;
      if (active && phase_q == PH_B) smp_d[1] = rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      smp_q   <= '1;
    end else begin
      phase_q <= phase_d;
      smp_q   <= smp_d;
    end
  end

  assign strobe = tick && active && (phase_q == PH_C);
  assign vote   = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx) | (smp_q[1] & rx);
endmodule

// File: rtl/mpuart_rx_ctrl.sv
module mpuart_rx_ctrl
  import mpuart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          strobe,
  input  logic          vote,
  output logic          active,
  output logic          align,
  output logic          frame_done,
  output logic          stop_bit,
  output logic [DW-1:0] shift_data
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);

  rx_state_e     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          prev_q, prev_d;

  always_comb begin
    prev_d = prev_q;
    if (tick) prev_d = rx;
  end

  assign align = tick && (state_q == ST_IDLE) && prev_q && !rx;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    case (state_q)
      ST_IDLE: begin
        if (align) state_d = ST_START;
      end
      ST_START: begin
        if (strobe) begin
          idx_d   = '0;
          state_d = vote ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (strobe) begin
          sh_d  = {vote, sh_q[DW-1:1]};
          idx_d = idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (strobe) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      prev_q  <= prev_d;
    end
  end

  assign active     = (state_q != ST_IDLE);
  assign frame_done = strobe && (state_q == ST_STOP);
  assign stop_bit   = vote;
  assign shift_data = sh_q;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              filter_en,
  input  logic              ready_clr,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_stop,
  output logic              rx_ready
);
  logic              rx_s;
  logic              active;
  logic              align;
  logic              strobe;
  logic              vote;
  logic              frame_done;
  logic              stop_bit;
  logic [DATA_W-1:0] shift_data;

  mpuart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_line),
    .dout  (rx_s)
  );

  mpuart_rx_sampler #(.OVS(OVS)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (os_tick),
    .active (active),
    .align  (align),
    .rx     (rx_s),
    .strobe (strobe),
    .vote   (vote)
  );

  mpuart_rx_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (os_tick),
    .rx         (rx_s),
    .strobe     (strobe),
    .vote       (vote),
    .active     (active),
    .align      (align),
    .frame_done (frame_done),
    .stop_bit   (stop_bit),
    .shift_data (shift_data)
  );

  logic              accept;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              stop_q, stop_d;
  logic              rdy_q, rdy_d;

  assign accept = frame_done && !rdy_q && (!filter_en || stop_bit);

  always_comb begin
    byte_d = byte_q;
    stop_d = stop_q;
    rdy_d  = rdy_q;
    if (ready_clr) rdy_d = 1'b0;
    if (accept) begin
      byte_d = shift_data;
      stop_d = stop_bit;
      rdy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      stop_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      byte_q <= byte_d;
      stop_q <= stop_d;
      rdy_q  <= rdy_d;
    end
  end

  assign rx_byte  = byte_q;
  assign rx_stop  = stop_q;
  assign rx_ready = rdy_q;
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              filter_en,
  input logic              ready_clr,
  input logic              frame_done,
  input logic              stop_bit,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_stop,
  input logic              rx_ready
);
  AST_READY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(frame_done)); // R2

  AST_DELIVER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !rx_ready && !filter_en) |=> (rx_ready && rx_stop == $past(stop_bit))); // R2

  AST_HOLD_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_ready) |-> ($stable(rx_byte) && $stable(rx_stop))); // R5

  AST_FILTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && filter_en && !stop_bit && !rx_ready) |=> !rx_ready); // R6

  AST_CLEAR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_clr && !frame_done) |=> !rx_ready); // R7

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ready_clr && !rx_ready && (!filter_en || stop_bit)) |=> rx_ready); // R7
endmodule

bind mpuart_rx mpuart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .filter_en  (filter_en),
  .ready_clr  (ready_clr),
  .frame_done (frame_done),
  .stop_bit   (stop_bit),
  .rx_byte    (rx_byte),
  .rx_stop    (rx_stop),
  .rx_ready   (rx_ready)
);

// File: tb/mpuart_rx_bench.sv
module mpuart_rx_bench;
  localparam int BIT_CLK = 64;
  localparam int NVEC    = 7;

  typedef struct packed {
    logic [7:0] d;
    logic       stop;
    logic       filt;
    logic       clr;
    logic       deliver;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'h3C, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h3C, 1'b1, 1'b0, 1'b1, 1'b1},
    '{8'h81, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h7E, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
    '{8'hFF, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rx_line;
  logic       filter_en;
  logic       ready_clr;
  logic [7:0] rx_byte;
  logic       rx_stop;
  logic       rx_ready;

  int checks   = 0;
  int failures = 0;

  logic [7:0] exp_byte;
  logic       exp_stop;
  logic       exp_rdy;

  always #2 clk = ~clk;

  mpuart_rx u_mpuart_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .rx_line   (rx_line),
    .filter_en (filter_en),
    .ready_clr (ready_clr),
    .rx_byte   (rx_byte),
    .rx_stop   (rx_stop),
    .rx_ready  (rx_ready)
  );

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stop, input int stop_len,
                      input logic [7:0] noise);
    @(negedge clk);
    rx_line = 1'b0;
    idle(BIT_CLK - 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx_line = d[i];
      if (noise[i]) begin
        idle(31);
        rx_line = ~d[i];
        idle(4);
        rx_line = d[i];
        idle(BIT_CLK - 36);
      end else begin
        idle(BIT_CLK - 1);
      end
    end
    @(negedge clk);
    rx_line = stop;
    idle(stop_len - 1);
    rx_line = 1'b1;
  endtask

  task automatic pulse_clr;
    @(negedge clk);
    ready_clr = 1'b1;
    @(negedge clk);
    ready_clr = 1'b0;
  endtask

  task automatic check_regs(input string req);
    chk({req, " rx_ready"}, {7'd0, rx_ready}, {7'd0, exp_rdy});
    chk({req, " rx_byte"}, rx_byte, exp_byte);
    chk({req, " rx_stop"}, {7'd0, rx_stop}, {7'd0, exp_stop});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    rx_line   = 1'b1;
    filter_en = 1'b0;
    ready_clr = 1'b0;
    exp_byte  = 8'h00;
    exp_stop  = 1'b0;
    exp_rdy   = 1'b0;
    idle(5);
    check_regs("R1 in reset");
    rst_n = 1'b1;
    idle(40);
    check_regs("R1 after reset");

    // Table walk: R2, R5, R6, R7
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].clr) begin
        pulse_clr();
        exp_rdy = 1'b0;
        idle(2);
        chk("R7 clear pulse", {7'd0, rx_ready}, 8'd0);
      end
      filter_en = VECS[i].filt;
      send(VECS[i].d, VECS[i].stop, BIT_CLK, 8'h00);
      idle(40);
      if (!exp_rdy && (!VECS[i].filt || VECS[i].stop)) begin
        exp_byte = VECS[i].d;
        exp_stop = VECS[i].stop;
        exp_rdy  = 1'b1;
      end
      chk("R5 R6 table deliver", {7'd0, rx_ready && !$isunknown(rx_ready)},
          {7'd0, exp_rdy});
      if (VECS[i].deliver) check_regs("R2 R6 delivered");
      else if (VECS[i].filt) check_regs("R6 dropped");
      else check_regs("R5 dropped");
    end
    filter_en = 1'b0;

    // R4: short low pulse is a false start
    pulse_clr();
    exp_rdy = 1'b0;
    @(negedge clk);
    rx_line = 1'b0;
    idle(16);
    rx_line = 1'b1;
    idle(BIT_CLK * 3);
    check_regs("R4 false start");
    send(8'h55, 1'b1, BIT_CLK, 8'h00);
    idle(40);
    exp_byte = 8'h55; exp_stop = 1'b1; exp_rdy = 1'b1;
    check_regs("R4 after false start");

    // R3: single-point disturbances inside bits
    pulse_clr();
    exp_rdy = 1'b0;
    send(8'h96, 1'b1, BIT_CLK, 8'b1010_0110);
    idle(40);
    exp_byte = 8'h96; exp_stop = 1'b1; exp_rdy = 1'b1;
    check_regs("R3 majority");

    // R8: next start edge early in the stop bit
    pulse_clr();
    exp_rdy = 1'b0;
    send(8'h12, 1'b1, 52, 8'h00);
    chk("R8 first byte", rx_byte, 8'h12);
    chk("R8 first ready", {7'd0, rx_ready}, 8'd1);
    fork
      send(8'h34, 1'b1, BIT_CLK, 8'h00);
      begin
        ready_clr = 1'b1;
        @(negedge clk);
        ready_clr = 1'b0;
      end
    join
    idle(40);
    exp_byte = 8'h34; exp_stop = 1'b1; exp_rdy = 1'b1;
    check_regs("R8 second frame");

    // R7: delivery and clear in the same cycle
    @(negedge clk);
    ready_clr = 1'b1;
    fork
      send(8'hC3, 1'b1, BIT_CLK, 8'h00);
      begin
        for (int n = 0; n < 12 * BIT_CLK; n++) begin
          @(negedge clk);
          if (n > 2 * BIT_CLK && rx_ready) break;
        end
        ready_clr = 1'b0;
      end
    join
    ready_clr = 1'b0;
    idle(40);
    exp_byte = 8'hC3; exp_stop = 1'b1; exp_rdy = 1'b1;
    check_regs("R7 set beats clear");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule